// File: doc/BRIEF.md
# Aligned DMA Segment Splitter

This block sits in front of a transfer engine whose segment length register holds at most 0x1FFF bytes. It takes a request, a sequence of buffer entries each holding a start address and a byte length, and turns it into a stream of segments the engine can run directly. An entry that already fits passes through as one segment. A longer entry is cut into chunks of nearly equal size with 4-byte-aligned lengths, so the request never ends in a tiny leftover transfer.

Entries arrive on a valid/ready port with a flag on the final entry of a request. Segments leave on a valid/ready port carrying address, length, an error flag, a last flag and a running segment count. The chunk size comes from two divisions done one after the other by an internal restoring divider that produces one quotient bit per cycle. Input is refused while a division runs or a segment is waiting. A start address that is not word aligned, or an entry of zero length, aborts the request. The rest of the request is then consumed and one error beat closes it. An empty request is sent as a single zero-length entry with the final-entry flag set.

Top module: `seg_splitter`

## Requirements
- R1: An entry with a length from 1 to 0x1FFF produces exactly one segment with that entry's address and length.
- R2: While the leftover length L of an entry is above 0x1FFF, the next chunk length is floor(L / ceil(L / 0x1FFC)) with bits 1 and 0 cleared. This is recomputed on each leftover. A leftover of 0x1FFF or less goes out unchanged as the final chunk of the entry.
- R3: The first chunk of an entry starts at the entry address. Each later chunk starts at the previous chunk's address plus the previous chunk's length.
- R4: Every segment without the error flag has a length from 1 to 0x1FFF.
- R5: An entry whose start address has bit 1 or bit 0 set produces no segments and aborts the request with an error.
- R6: An entry with length zero is rejected the same way. An empty request, a lone zero-length entry with the final-entry flag, yields only an error beat.
- R7: After an error, the remaining entries up to and including the final-entry flag are accepted and discarded. Exactly one beat then follows with error=1, last=1 and length=0. Its count equals the number of segments already sent for that request.
- R8: In an error-free request, only the final chunk of the final entry has last=1. Each segment's count field equals its 1-based position within the request, and the count restarts at the next request.
- R9: While a segment is valid and not taken, every output field stays stable and valid stays high.
- R10: Input ready is low whenever a segment is offered or a division is running, and high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Entry offered |
| in_ready | output | 1 | Entry accepted when high together with in_valid |
| in_addr | input | ADDR_W | Entry start address in bytes |
| in_len | input | LEN_W | Entry length in bytes |
| in_last | input | 1 | Entry is the final one of its request |
| out_valid | output | 1 | Segment offered |
| out_ready | input | 1 | Segment taken when high together with out_valid |
| out_addr | output | ADDR_W | Segment start address |
| out_len | output | LEN_W | Segment length in bytes, zero on an error beat |
| out_err | output | 1 | Request aborted |
| out_last | output | 1 | Final beat of the request |
| out_count | output | CNT_W | Segment position within the request, or segments sent before an error |

## Verification
Lengths just below, at and just above 0x1FFF show where the pass-through and split paths meet. The 0x2000 case must give two 0x1000 chunks rather than a full chunk plus a 1-byte tail. The largest length checks that the count and chunk divisions hold at full width. Misaligned and zero-length entries placed first, in the middle and alone show that rejection discards the rest of the request and that the count reports only what was already sent. Random mixes of entry counts and lengths, under a randomly stalling consumer, exercise the address chain, the per-request count restart and output hold under back-pressure.

// File: rtl/seg_splitter_pkg.sv
package seg_splitter_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_DIVC,
        ST_DIVL,
        ST_EMIT,
        ST_ERR
    } seg_st_e;

endpackage

// File: rtl/seg_rdiv.sv
module seg_rdiv #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int SW = $clog2(W + 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [SW-1:0] step;
        logic [W-1:0]  rem;
        logic [W-1:0]  q;
        logic [W-1:0]  den;
    } div_t;

    div_t d, q;

    logic [W:0] trial;
    logic [W:0] diff;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        trial  = {q.rem, q.q[W-1]};
        diff   = trial - {1'b0, q.den};
        if (start) begin
            d.busy = 1'b1;
            d.step = SW'(W);
            d.rem  = '0;
            d.q    = num;
            d.den  = den;
        end else if (q.busy) begin
            if (!diff[W]) begin
                d.rem = diff[W-1:0];
                d.q   = {q.q[W-2:0], 1'b1};
            end else begin
                d.rem = trial[W-1:0];
                d.q   = {q.q[W-2:0], 1'b0};
            end
            d.step = q.step - SW'(1);
            if (q.step == SW'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = q.done;
    assign quo  = q.q;

endmodule

// File: rtl/seg_splitter.sv
module seg_splitter
    import seg_splitter_pkg::*;
#(
    parameter int          ADDR_W  = 32,
    parameter int          LEN_W   = 16,
    parameter int          CNT_W   = 8,
    parameter int unsigned MAX_SEG = 32'h1FFF,
    parameter int          ALIGN_B = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LEN_W-1:0]  in_len,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [LEN_W-1:0]  out_len,
    output logic              out_err,
    output logic              out_last,
    output logic [CNT_W-1:0]  out_count
);
    localparam int               DW      = LEN_W + 1;
    localparam logic [LEN_W-1:0] MAX_L   = MAX_SEG[LEN_W-1:0];
    localparam logic [LEN_W-1:0] AMASK_L = LEN_W'((32'd1 << ALIGN_B) - 32'd1);
    localparam logic [LEN_W-1:0] STEP_L  = MAX_L & ~AMASK_L;

    typedef struct packed {
        seg_st_e             st;
        logic [ADDR_W-1:0]   addr;
        logic [LEN_W-1:0]    rem;
        logic [LEN_W-1:0]    chunk;
        logic                last;
        logic [CNT_W-1:0]    cnt;
    } ctl_t;

    ctl_t d, q;

    logic             div_start;
    logic [DW-1:0]    div_num;
    logic [DW-1:0]    div_den;
    logic             div_done;
    logic [DW-1:0]    div_quo;

    logic             plan_go;
    logic [LEN_W-1:0] plan_rem;
    logic             final_chunk;

    seg_rdiv #(.W(DW)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quo   (div_quo)
    );

    assign final_chunk = (q.rem == q.chunk);

    always_comb begin
        d         = q;
        div_start = 1'b0;
        div_num   = '0;
        div_den   = '0;
        plan_go   = 1'b0;
        plan_rem  = '0;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_addr  = q.addr;
        out_len   = '0;
        out_err   = 1'b0;
        out_last  = 1'b0;
        out_count = q.cnt;

        unique case (q.st)
            ST_IDLE: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    d.addr = in_addr;
                    d.last = in_last;
                    d.rem  = in_len;
                    if ((in_addr[ALIGN_B-1:0] != '0) || (in_len == '0)) begin
                        d.st = in_last ? ST_ERR : ST_DRAIN;
                    end else begin
                        plan_go  = 1'b1;
                        plan_rem = in_len;
                    end
                end
            end
            ST_DRAIN: begin
                in_ready = 1'b1;
                if (in_valid && in_last) d.st = ST_ERR;
            end
            ST_DIVC: begin
                if (div_done) begin
                    div_start = 1'b1;
                    div_num   = {1'b0, q.rem};
                    div_den   = div_quo;
                    d.st      = ST_DIVL;
                end
            end
            ST_DIVL: begin
                if (div_done) begin
                    d.chunk = div_quo[LEN_W-1:0] & ~AMASK_L;
                    d.st    = ST_EMIT;
                end
            end
            ST_EMIT: begin
                out_valid = 1'b1;
                out_len   = q.chunk;
                out_last  = q.last && final_chunk;
                out_count = q.cnt + CNT_W'(1);
                if (out_ready) begin
                    d.cnt  = q.cnt + CNT_W'(1);
                    d.addr = q.addr + {{(ADDR_W-LEN_W){1'b0}}, q.chunk};
                    d.rem  = q.rem - q.chunk;
                    if (final_chunk) begin
                        d.st = ST_IDLE;
                        if (q.last) d.cnt = '0;
                    end else begin
                        plan_go  = 1'b1;
                        plan_rem = q.rem - q.chunk;
                    end
                end
            end
            ST_ERR: begin
                out_valid = 1'b1;
                out_err   = 1'b1;
                out_last  = 1'b1;
                if (out_ready) begin
                    d.st  = ST_IDLE;
                    d.cnt = '0;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (plan_go) begin
            if (plan_rem <= MAX_L) begin
                d.chunk = plan_rem;
                d.st    = ST_EMIT;
            end else begin
                div_start = 1'b1;
                div_num   = {1'b0, plan_rem} + {1'b0, STEP_L} - DW'(1);
                div_den   = {1'b0, STEP_L};
                d.st      = ST_DIVC;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/seg_splitter_chk.sv
module seg_splitter_chk #(
    parameter int          ADDR_W  = 32,
    parameter int          LEN_W   = 16,
    parameter int          CNT_W   = 8,
    parameter int unsigned MAX_SEG = 32'h1FFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic [LEN_W-1:0]  out_len,
    input logic              out_err,
    input logic              out_last,
    input logic [CNT_W-1:0]  out_count
);
    localparam logic [LEN_W-1:0] MAX_L = MAX_SEG[LEN_W-1:0];

    // R4
    seg_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err) |-> (out_len != '0 && out_len <= MAX_L));

    // R7
    err_beat_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_last && out_len == '0));

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_len)
            && $stable(out_err) && $stable(out_last) && $stable(out_count)));

    // R10
    no_accept_while_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R8
    last_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last && !out_err) |-> (out_count != '0));

endmodule

bind seg_splitter seg_splitter_chk #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .CNT_W  (CNT_W),
    .MAX_SEG(MAX_SEG)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_addr (out_addr),
    .out_len  (out_len),
    .out_err  (out_err),
    .out_last (out_last),
    .out_count(out_count)
);

// File: tb/seg_splitter_tb.sv
module seg_splitter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_addr = '0;
    logic [15:0] in_len = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_addr;
    logic [15:0] out_len;
    logic        out_err;
    logic        out_last;
    logic [7:0]  out_count;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [31:0] q_addr[$];
    logic [15:0] q_len[$];
    logic        q_err[$];
    logic        q_last[$];
    logic [7:0]  q_cnt[$];
    string       q_tag[$];

    logic [31:0] ra[8];
    logic [15:0] rl[8];

    always #4 clk = ~clk;

    seg_splitter dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
        .in_len(in_len), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_len(out_len), .out_err(out_err), .out_last(out_last),
        .out_count(out_count)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int unsigned next_chunk(input int unsigned rem);
        int unsigned n;
        if (rem <= 32'h1FFF) return rem;
        n = (rem + 32'h1FFB) / 32'h1FFC;
        return (rem / n) & ~32'd3;
    endfunction

    task automatic send_entry(input logic [31:0] a, input logic [15:0] l, input logic lst);
        bit r;
        @(negedge clk);
        in_valid = 1'b1;
        in_addr  = a;
        in_len   = l;
        in_last  = lst;
        forever begin
            #1;
            r = in_ready;
            @(posedge clk);
            if (r) break;
            @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // expectations built from the requirements, then the entries are driven
    task automatic run_req(input int n);
        int unsigned rem, ch, cnt;
        logic [31:0] a;
        bit err;
        string etag;
        cnt = 0;
        err = 0;
        etag = "";
        for (int i = 0; i < n; i++) begin
            if (err) continue;
            if (ra[i][1:0] != 2'b00) begin
                err = 1; etag = "R5"; continue;
            end
            if (rl[i] == 16'd0) begin
                err = 1; etag = "R6"; continue;
            end
            rem = rl[i];
            a = ra[i];
            while (rem != 0) begin
                ch = next_chunk(rem);
                cnt++;
                q_addr.push_back(a);
                q_len.push_back(16'(ch));
                q_err.push_back(1'b0);
                q_last.push_back((i == n - 1) && (rem == ch));
                q_cnt.push_back(8'(cnt));
                q_tag.push_back(rl[i] <= 16'h1FFF ? "R1" : "R2");
                a = a + ch;
                rem = rem - ch;
            end
        end
        if (err) begin
            q_addr.push_back('0);
            q_len.push_back('0);
            q_err.push_back(1'b1);
            q_last.push_back(1'b1);
            q_cnt.push_back(8'(cnt));
            q_tag.push_back(etag);
        end
        for (int i = 0; i < n; i++) send_entry(ra[i], rl[i], i == n - 1);
    endtask

    // output monitor with random back-pressure
    initial begin
        logic        pv = 0;
        logic [31:0] pa;
        logic [15:0] pl;
        logic        pe, pls;
        logic [7:0]  pc;
        wait (rst_n);
        forever begin
            @(negedge clk);
            out_ready = ($urandom % 4) != 0;
            #1;
            if (pv) begin
                check(out_valid && out_addr == pa && out_len == pl && out_err == pe
                      && out_last == pls && out_count == pc, "R9", "held beat changed",
                      {out_addr, out_len}, {pa, pl});
            end
            if (out_valid)
                check(!in_ready, "R10", "in_ready during output", in_ready, 0);
            if (out_valid && out_ready) begin
                if (q_len.size() == 0) begin
                    check(0, "R8", "unexpected beat", out_len, 0);
                end else begin
                    logic [31:0] ea; logic [15:0] el; logic ee, elst; logic [7:0] ec; string t;
                    ea = q_addr.pop_front(); el = q_len.pop_front(); ee = q_err.pop_front();
                    elst = q_last.pop_front(); ec = q_cnt.pop_front(); t = q_tag.pop_front();
                    check(out_err == ee, t, "err flag", out_err, ee);
                    if (ee) begin
                        check(out_len == 0 && out_last, "R7", "error beat len/last",
                              {out_len, out_last}, 1);
                        check(out_count == ec, "R7", "error beat count", out_count, ec);
                    end else begin
                        check(out_len == el, t, "segment length", out_len, el);
                        check(out_addr == ea, "R3", "segment address", out_addr, ea);
                        check(out_len != 0 && out_len <= 16'h1FFF, "R4", "length range", out_len, el);
                        check(out_last == elst, "R8", "last flag", out_last, elst);
                        check(out_count == ec, "R8", "segment count", out_count, ec);
                    end
                end
            end
            pv = out_valid && !out_ready;
            pa = out_addr; pl = out_len; pe = out_err; pls = out_last; pc = out_count;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(posedge clk);
        #1;
        check(out_valid == 0, "R10", "out_valid after reset", out_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(in_ready == 1, "R10", "in_ready after reset", in_ready, 1);

        // R1 boundary: exactly the largest single segment
        ra[0] = 32'h1000; rl[0] = 16'h1FFF; run_req(1);
        // R2: 0x2000 splits into two equal 0x1000 chunks
        ra[0] = 32'h8000; rl[0] = 16'h2000; run_req(1);
        // R2: largest length
        ra[0] = 32'h40000; rl[0] = 16'hFFFF; run_req(1);
        // R2/R3: odd length just above the limit followed by tiny entries
        ra[0] = 32'h100; rl[0] = 16'h2001; ra[1] = 32'h9000; rl[1] = 16'd1;
        ra[2] = 32'hA004; rl[2] = 16'h1FFE; run_req(3);
        // R5/R7: misaligned middle entry, rest of request discarded
        ra[0] = 32'h2000; rl[0] = 16'h0040; ra[1] = 32'h0102; rl[1] = 16'h0010;
        ra[2] = 32'h3000; rl[2] = 16'h0020; run_req(3);
        // R5: misaligned lone entry
        ra[0] = 32'h0001; rl[0] = 16'h0008; run_req(1);
        // R6: empty request
        ra[0] = 32'h0; rl[0] = 16'h0; run_req(1);
        // R6: zero-length first entry, later valid entries discarded
        ra[0] = 32'h500; rl[0] = 16'h0; ra[1] = 32'h600; rl[1] = 16'h30; run_req(2);
        // R8: count restarts after an error
        ra[0] = 32'h700; rl[0] = 16'h3000; ra[1] = 32'h9000; rl[1] = 16'h0200; run_req(2);

        for (int k = 0; k < 50; k++) begin
            int n;
            n = 1 + int'($urandom % 4);
            for (int i = 0; i < n; i++) begin
                int unsigned sel;
                sel = $urandom % 20;
                ra[i] = {$urandom} & 32'hFFFF_FFFC;
                if (sel == 0)      ra[i] = ra[i] | 32'(1 + $urandom % 3);
                if (sel == 1)      rl[i] = 16'd0;
                else if (sel < 8)  rl[i] = 16'(1 + $urandom % 16'h1FFF);
                else if (sel < 12) rl[i] = 16'(16'h1FFC + $urandom % 8);
                else               rl[i] = 16'(1 + $urandom % 16'hFFFF);
            end
            run_req(n);
        end

        for (int w = 0; w < 20000 && q_len.size() != 0; w++) @(posedge clk);
        repeat (4) @(posedge clk);
        check(q_len.size() == 0, "R8", "beats outstanding", q_len.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule